// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block recovers asynchronous serial characters from a single input line. A strobe that pulses once for every sixteenth of a bit period paces all the timing. The block waits in idle for the line to fall. It then times each bit against that strobe and settles every bit value by a vote over three samples taken near the middle of the bit. A start bit that reads high at its middle is treated as noise, and the block drops back to idle without storing anything.

The character has 5 to 8 data bits, sent least significant bit first. An optional parity bit follows, then a stop bit. When the stop bit is sampled, the character goes into a holding register and a ready flag is raised. Parity, framing, overrun and break conditions are recorded as sticky flags. A single read strobe from the register side clears the ready flag and all error flags together. The line input passes through a synchronizer, so it may change at any time relative to the clock.

Top module: `serial_rx`

## Requirements
- R1: A new character begins only on a 16x strobe where the line reads low after having read high on the previous strobe, and only while the receiver is idle. A falling edge inside a character does not restart reception.
- R2: Counting the start-detect strobe as tick 0, the line is sampled on ticks 7, 8 and 9 of every 16-tick bit period. The bit value is the majority of those three samples, so one disturbed sample does not change it.
- R3: If the majority value of the start bit is high, the receiver returns to idle. No character is stored and no flag changes.
- R4: `char_len` selects the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data arrives least significant bit first. Bits of `rx_data` above the character length read zero.
- R5: With `par_en`=1, one parity bit follows the data. `par_even`=1 selects even parity (data plus parity bit hold an even number of ones) and `par_even`=0 selects odd parity. A mismatch sets `err_parity`. With `par_en`=0 there is no parity slot and `err_parity` is never set.
- R6: A stop bit whose majority value is low sets `err_frame`. The character is still stored.
- R7: If every data bit, the parity bit (when enabled) and the stop bit all read low, `err_break` and `err_frame` are set and `rx_data` is 0. A line held low for several character times loads only one character, because no new falling edge appears.
- R8: If a character completes while `data_ready` is already set and `rd_ack` is not asserted in that cycle, `err_overrun` is set and the new character replaces the old one.
- R9: Completing a character sets `data_ready` on the next clock. A one-cycle `rd_ack` clears `data_ready` and all four error flags. If a character completes in the same cycle as `rd_ack`, the new character and its flags take effect.
- R10: After reset, `data_ready`, all error flags and `rx_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rxd | input | 1 | Serial line, idle high, asynchronous to clk |
| char_len | input | 2 | Data bit count code (00=5 .. 11=8) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| rd_ack | input | 1 | Read strobe: clears ready and error flags |
| rx_data | output | 8 | Holding register, received character |
| data_ready | output | 1 | A character is waiting to be read |
| err_parity | output | 1 | Sticky parity mismatch |
| err_frame | output | 1 | Sticky stop-bit-low flag |
| err_overrun | output | 1 | Sticky overwrite of an unread character |
| err_break | output | 1 | Sticky all-low character flag |

## Verification
The bench injects a one-cycle pulse into the middle of a start bit and into a data bit. A receiver that trusted one sample would abort the start or flip the data bit. A short low pulse on the idle line must leave no character, where a design without the mid-start check would store garbage. A line held low for two character times must give exactly one zero character with break and framing flags and no overrun; a receiver that restarted on level instead of on an edge would overrun. Random frames cover all lengths, parity modes, bad parity, low stop bits and several strobe rates, which exposes wrong bit order, leftover upper bits and an inverted parity sense.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int unsigned MAX_BITS = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                perr;
    logic                ferr;
    logic                brk;
  } rx_char_t;

  // Mask of valid data bits for a length code (00 -> 5 bits .. 11 -> 8 bits)
  function automatic logic [MAX_BITS-1:0] len_mask(input logic [1:0] len);
    logic [MAX_BITS-1:0] all_ones;
    all_ones = '1;
    return all_ones >> (3'd3 - {1'b0, len});
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = line_in;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], line_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign line_sync = chain_q[STAGES-1];

endmodule

// File: rtl/rx_voter.sv
module rx_voter #(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW  = $clog2(OSR),
  localparam int unsigned MID = OSR / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [CW-1:0] phase,
  output logic          vote_valid,
  output logic          vote_bit
);

  logic samp_a_q, samp_a_d;
  logic samp_b_q, samp_b_d;
  logic at_first, at_second, at_third;

  always_comb begin
    at_first  = tick && (phase == CW'(MID - 1));
    at_second = tick && (phase == CW'(MID));
    at_third  = tick && (phase == CW'(MID + 1));
    samp_a_d  = at_first  ? line : samp_a_q;
    samp_b_d  = at_second ? line : samp_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_a_q <= 1'b1;
      samp_b_q <= 1'b1;
    end else begin
      samp_a_q <= samp_a_d;
      samp_b_q <= samp_b_d;
    end
  end

  assign vote_valid = at_third;
  assign vote_bit   = (samp_a_q & samp_b_q) | (samp_a_q & line) | (samp_b_q & line);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR = 16,
  localparam int unsigned CW = $clog2(OSR)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          line,
  input  logic [1:0]    char_len,
  input  logic          par_en,
  input  logic          par_even,
  input  logic          vote_valid,
  input  logic          vote_bit,
  output logic [CW-1:0] phase,
  output logic          busy,
  output logic          chr_done,
  output rx_char_t      chr
);

  rx_state_e           state_q, state_d;
  logic [CW-1:0]       tcnt_q, tcnt_d;
  logic [2:0]          bcnt_q, bcnt_d;
  logic [MAX_BITS-1:0] shreg_q, shreg_d;
  logic                par_q, par_d;
  logic                ones_q, ones_d;
  logic                prev_q, prev_d;
  logic                last_bit;

  always_comb begin
    state_d  = state_q;
    tcnt_d   = tcnt_q;
    bcnt_d   = bcnt_q;
    shreg_d  = shreg_q;
    par_d    = par_q;
    ones_d   = ones_q;
    prev_d   = tick ? line : prev_q;
    chr_done = 1'b0;
    chr      = '{data: shreg_q, perr: par_en && (par_q == par_even),
                 ferr: !vote_bit, brk: !vote_bit && !ones_q};
    last_bit = (bcnt_q == {1'b1, char_len});

    if (state_q == ST_IDLE) begin
      if (tick && prev_q && !line) begin
        state_d = ST_START;
        tcnt_d  = CW'(1);
        bcnt_d  = '0;
        shreg_d = '0;
        par_d   = 1'b0;
        ones_d  = 1'b0;
      end
    end else begin
      if (tick) begin
        tcnt_d = (tcnt_q == CW'(OSR - 1)) ? '0 : tcnt_q + 1'b1;
      end
      if (vote_valid) begin
        unique case (state_q)
          ST_START: state_d = vote_bit ? ST_IDLE : ST_DATA;
          ST_DATA: begin
            shreg_d[bcnt_q] = vote_bit;
            par_d           = par_q ^ vote_bit;
            ones_d          = ones_q | vote_bit;
            bcnt_d          = bcnt_q + 1'b1;
            if (last_bit) state_d = par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR: begin
            par_d   = par_q ^ vote_bit;
            ones_d  = ones_q | vote_bit;
            state_d = ST_STOP;
          end
          ST_STOP: begin
            chr_done = 1'b1;
            state_d  = ST_IDLE;
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      ones_q  <= 1'b0;
      prev_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
      ones_q  <= ones_d;
      prev_q  <= prev_d;
    end
  end

  assign phase = tcnt_q;
  assign busy  = (state_q != ST_IDLE);

endmodule

// File: rtl/rx_holding.sv
module rx_holding
  import serial_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chr_done,
  input  rx_char_t            chr,
  input  logic                rd_ack,
  output logic [MAX_BITS-1:0] rx_data,
  output logic                data_ready,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun,
  output logic                err_break
);

  logic [MAX_BITS-1:0] data_q, data_d;
  logic dr_q, dr_d, pe_q, pe_d, fe_q, fe_d, oe_q, oe_d, bi_q, bi_d;

  always_comb begin
    data_d = data_q;
    dr_d   = dr_q;
    pe_d   = pe_q;
    fe_d   = fe_q;
    oe_d   = oe_q;
    bi_d   = bi_q;
    if (rd_ack) begin
      dr_d = 1'b0;
      pe_d = 1'b0;
      fe_d = 1'b0;
      oe_d = 1'b0;
      bi_d = 1'b0;
    end
    if (chr_done) begin
      data_d = chr.data;
      dr_d   = 1'b1;
      pe_d   = pe_d | chr.perr;
      fe_d   = fe_d | chr.ferr;
      bi_d   = bi_d | chr.brk;
      oe_d   = oe_d | (dr_q & ~rd_ack);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dr_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      oe_q   <= 1'b0;
      bi_q   <= 1'b0;
    end else begin
      data_q <= data_d;
      dr_q   <= dr_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      oe_q   <= oe_d;
      bi_q   <= bi_d;
    end
  end

  assign rx_data     = data_q;
  assign data_ready  = dr_q;
  assign err_parity  = pe_q;
  assign err_frame   = fe_q;
  assign err_overrun = oe_q;
  assign err_break   = bi_q;

endmodule

// File: rtl/serial_rx.sv
module serial_rx
  import serial_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rxd,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rd_ack,
  output logic [7:0] rx_data,
  output logic       data_ready,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun,
  output logic       err_break
);

  localparam int unsigned CW = $clog2(OSR);

  logic [1:0]    rst_pipe_q;
  logic          rst_core_n;
  logic          rxd_s;
  logic [CW-1:0] phase;
  logic          vote_valid, vote_bit;
  logic          busy, chr_done;
  rx_char_t      chr;

  // Reset asserts at once and is released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .line_in  (rxd),
    .line_sync(rxd_s)
  );

  rx_voter #(.OSR(OSR)) u_vote (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick16),
    .line      (rxd_s),
    .phase     (phase),
    .vote_valid(vote_valid),
    .vote_bit  (vote_bit)
  );

  rx_frame_fsm #(.OSR(OSR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick      (tick16),
    .line      (rxd_s),
    .char_len  (char_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .vote_valid(vote_valid),
    .vote_bit  (vote_bit),
    .phase     (phase),
    .busy      (busy),
    .chr_done  (chr_done),
    .chr       (chr)
  );

  rx_holding u_hold (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .chr_done   (chr_done),
    .chr        (chr),
    .rd_ack     (rd_ack),
    .rx_data    (rx_data),
    .data_ready (data_ready),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun),
    .err_break  (err_break)
  );

endmodule

// File: rtl/serial_rx_checker.sv
module serial_rx_checker
  import serial_rx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       line,
  input logic       busy,
  input logic       chr_done,
  input logic       rd_ack,
  input logic [1:0] char_len,
  input logic [7:0] rx_data,
  input logic       data_ready,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun,
  input logic       err_break
);

  assert_idle_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(tick && !line)) |=> !busy);

  assert_done_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |-> tick);

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |=> ((rx_data & ~len_mask($past(char_len))) == 8'h00));

  assert_break_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_break) |-> (rx_data == 8'h00) && err_frame);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && data_ready && !rd_ack) |=> err_overrun);

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !chr_done) |=>
      !data_ready && !err_parity && !err_frame && !err_overrun && !err_break);

  assert_done_sets_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chr_done |=> data_ready);

endmodule

bind serial_rx serial_rx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .tick       (tick16),
  .line       (rxd_s),
  .busy       (busy),
  .chr_done   (chr_done),
  .rd_ack     (rd_ack),
  .char_len   (char_len),
  .rx_data    (rx_data),
  .data_ready (data_ready),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_overrun(err_overrun),
  .err_break  (err_break)
);

// File: tb/tb_serial_rx.sv
module tb_serial_rx;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick16;
  logic       rxd;
  logic [1:0] char_len;
  logic       par_en, par_even, rd_ack;
  logic [7:0] rx_data;
  logic       data_ready, err_parity, err_frame, err_overrun, err_break;

  int checks = 0;
  int fails  = 0;
  int tdiv   = 1;
  int tcount = 0;
  int cycles = 0;
  logic done_flag = 1'b0;

  serial_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .char_len(char_len), .par_en(par_en), .par_even(par_even), .rd_ack(rd_ack),
    .rx_data(rx_data), .data_ready(data_ready), .err_parity(err_parity),
    .err_frame(err_frame), .err_overrun(err_overrun), .err_break(err_break)
  );

  always #5 clk = ~clk;

  // 16x strobe with a bench-chosen divider
  always @(negedge clk) begin
    tick16 = (tcount == 0);
    tcount = (tcount + 1 >= tdiv) ? 0 : tcount + 1;
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000 && !done_flag) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // One bit; optionally a single inverted cycle at mid-bit
  task automatic drive_bit(input logic v, input bit glitch);
    int len;
    len = 16 * tdiv;
    if (glitch) begin
      hold_line(v, 8 * tdiv);
      hold_line(~v, 1);
      hold_line(v, len - 8 * tdiv - 1);
    end else begin
      hold_line(v, len);
    end
  endtask

  function automatic logic [7:0] mask_of(input int len);
    return 8'hFF >> (8 - len);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input bit even);
    return even ? ^d : ~(^d);
  endfunction

  // gb: -1 none, 0 start bit, k data bit k-1
  task automatic send_frame(input logic [7:0] d, input int len, input bit pe,
                            input bit pev, input bit flip, input logic stopv,
                            input int gb);
    logic [7:0] dm;
    logic       pb;
    dm = d & mask_of(len);
    pb = par_bit(dm, pev) ^ flip;
    drive_bit(1'b0, gb == 0);
    for (int i = 0; i < len; i++) drive_bit(dm[i], gb == i + 1);
    if (pe) drive_bit(pb, 1'b0);
    drive_bit(stopv, 1'b0);
    drive_bit(1'b1, 1'b0);
    if (!stopv) drive_bit(1'b1, 1'b0);
  endtask

  task automatic setup(input int len, input bit pe, input bit pev);
    char_len = 2'(len - 5);
    par_en   = pe;
    par_even = pev;
  endtask

  task automatic do_read();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic frame_check(input logic [7:0] d, input int len, input bit pe,
                             input bit pev, input bit flip, input logic stopv,
                             input int gb, input string tag);
    logic [7:0] dm;
    logic       pb, brk;
    setup(len, pe, pev);
    send_frame(d, len, pe, pev, flip, stopv, gb);
    dm  = d & mask_of(len);
    pb  = par_bit(dm, pev) ^ flip;
    brk = (dm == 0) && (!pe || !pb) && !stopv;
    check({tag, " R9 ready"}, data_ready, 1);
    check({tag, " R4 data"}, rx_data, dm);
    check({tag, " R5 parity"}, err_parity, pe && flip);
    check({tag, " R6 frame"}, err_frame, !stopv);
    check({tag, " R7 break"}, err_break, brk);
    check({tag, " R8 no overrun"}, err_overrun, 0);
    do_read();
    check({tag, " R9 cleared"},
          {data_ready, err_parity, err_frame, err_overrun, err_break}, 0);
  endtask

  initial begin
    int seed;
    seed     = 32'h5A17;
    void'($urandom(seed));
    rst_n    = 1'b0;
    rxd      = 1'b1;
    rd_ack   = 1'b0;
    setup(8, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 reset outputs",
          {rx_data, data_ready, err_parity, err_frame, err_overrun, err_break}, 0);
    hold_line(1'b1, 32);

    // R4 all lengths, directed
    frame_check(8'hA5, 8, 0, 0, 0, 1'b1, -1, "len8");
    frame_check(8'hFF, 5, 0, 0, 0, 1'b1, -1, "len5 upper");
    frame_check(8'h5B, 6, 1, 1, 0, 1'b1, -1, "len6 even");
    frame_check(8'h3C, 7, 1, 0, 1, 1'b1, -1, "len7 odd bad");

    // R2 majority: single-cycle glitches in start bit and in a data bit
    tdiv = 1;
    frame_check(8'h00, 8, 0, 0, 0, 1'b1, 0, "R2 start glitch");
    frame_check(8'h81, 8, 0, 0, 0, 1'b1, 4, "R2 data glitch");

    // R3 false start: short low pulse leaves nothing stored
    hold_line(1'b0, 4);
    hold_line(1'b1, 64);
    check("R3 false start no ready", data_ready, 0);
    check("R3 false start no frame flag", err_frame, 0);
    frame_check(8'h6E, 8, 0, 0, 0, 1'b1, -1, "R3 recover");

    // R6 low stop with nonzero data
    frame_check(8'h42, 8, 1, 1, 0, 1'b0, -1, "R6 stop low");

    // R7 line held low for two character times
    setup(8, 1, 1);
    hold_line(1'b0, 2 * 11 * 16 * tdiv);
    hold_line(1'b1, 32 * tdiv);
    check("R7 break ready", data_ready, 1);
    check("R7 break data", rx_data, 0);
    check("R7 break flag", err_break, 1);
    check("R7 break frame", err_frame, 1);
    check("R7 single char no overrun", err_overrun, 0);
    do_read();
    hold_line(1'b1, 200);
    check("R7 no second char", data_ready, 0);

    // R8 overrun: two characters without a read
    setup(8, 0, 0);
    send_frame(8'h11, 8, 0, 0, 0, 1'b1, -1);
    send_frame(8'hC7, 8, 0, 0, 0, 1'b1, -1);
    check("R8 overrun flag", err_overrun, 1);
    check("R8 newer data kept", rx_data, 8'hC7);
    do_read();
    check("R8 overrun cleared", err_overrun, 0);

    // R1 / R4 / R5 / R6 random frames over several strobe rates
    for (int n = 0; n < 40; n++) begin
      int len;
      bit pe, pev, flip;
      logic stopv;
      logic [7:0] d;
      tdiv  = 1 + ($urandom % 3);
      len   = 5 + ($urandom % 4);
      pe    = $urandom % 2;
      pev   = $urandom % 2;
      flip  = pe && (($urandom % 5) == 0);
      stopv = (($urandom % 6) != 0);
      d     = 8'($urandom);
      if (($urandom % 8) == 0) d = 8'h00;
      frame_check(d, len, pe, pev, flip, stopv, -1, "R1 random");
    end

    done_flag = 1'b1;
    summary();
  end

endmodule